// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of several software localities currently owns a memory-mapped security device. Each locality sees its own register window, and the first byte of that window is an access-control byte. Through that byte a locality asks for the device, gives it up, or forcibly takes it from a lower-numbered locality. The byte also shows whether other localities are waiting and whether the device was taken away. A locality window that is not implemented reads as all ones, which lets software probe for presence.

The block sits behind a simple synchronous register port. A request is a single-cycle pulse carrying address, write enable and a data byte. The acknowledge follows exactly one cycle later. For reads, the returned byte reflects the ownership state at the edge where the request was sampled. Writes take effect at that same edge. When the device becomes free, the waiting locality with the highest number receives it at once.

Top module: `loc_access_arb`

## Requirements
- R1: After reset no locality is active, no request is pending and no seized flag is set. Offset 0 of every implemented locality then reads 0x81 while `os_established` is 0.
- R2: Every cycle with `bus_req` high is followed, exactly one cycle later, by a one-cycle `bus_ack`. For a read, `bus_rdata` then holds the byte that reflects the state at the request edge. No acknowledge appears without a request.
- R3: The access byte has a fixed layout. Bit 7 is always 1. Bit 5 is active. Bit 4 is seized. Bit 2 is pending. Bit 1 is request. Bit 6 and bit 3 read 0. If a locality writes 1 to bit 1 while no one owns the device, that locality becomes active at the same edge, and its request bit reads 0.
- R4: If a locality writes bit 1 while another locality owns the device, its request bit reads 1 and ownership does not change. Every locality other than a requester reads bit 2 as 1 while any other locality has a request set. If the owner writes bit 1, the write is ignored.
- R5: When the owner writes 1 to bit 5, it gives up the device. If other requests are waiting, ownership passes to one of them at that same edge.
- R6: When the device is free and several localities are requesting, the highest-numbered requester is granted.
- R7: A locality that writes 1 to bit 3 becomes active if there is no owner or the owner has a lower number. A lower-numbered owner that is displaced this way loses active and reads bit 4 as 1. A seize from a locality numbered at or below the owner is ignored.
- R8: The seized flag stays set until that same locality writes 1 to bit 5. Writing bit 5 also drops that locality's own request.
- R9: Bit 0 of the access byte reads as the inverse of the `os_established` input.
- R10: Any locality index at or above NLOC (5, 6 and 7 by default) reads 0xFF at every offset. Writes to such an index change nothing.
- R11: Offsets other than 0 in an implemented locality window read 0x00. Writes to those offsets change nothing.
- R12: When one write sets several command bits, bit 5 takes precedence over bit 3, and bit 3 takes precedence over bit 1. Only the highest-priority command is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Single-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | LOC_BITS+OFF_BITS | Locality index in the upper LOC_BITS bits, byte offset below |
| bus_wdata | input | 8 | Write byte |
| os_established | input | 1 | 1 when a trusted OS has been established |
| bus_ack | output | 1 | Acknowledge, one cycle after the request |
| bus_rdata | output | 8 | Read byte, valid with `bus_ack` |

## Verification
The assertions assume that `bus_req` is a single-cycle pulse and that `bus_we`, `bus_addr` and `bus_wdata` are valid whenever it is high. They also assume that requests arrive at most once per cycle. The bench drives all inputs on the falling edge and keeps each request high for exactly one cycle. It mixes directed ownership scenarios with random accesses. The random accesses are biased toward offset 0 of locality windows 0 to 7, so every command bit combination reaches both implemented and absent windows.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int LOC_MAX = 8;
  localparam int IDX_W   = 3;

  // access byte bit positions
  localparam int B_EST   = 0;
  localparam int B_REQ   = 1;
  localparam int B_PEND  = 2;
  localparam int B_SEIZE = 3;
  localparam int B_SZD   = 4;
  localparam int B_ACT   = 5;
  localparam int B_VALID = 7;

  typedef enum logic [1:0] {CMD_NONE, CMD_REL, CMD_SEIZE, CMD_REQ} cmd_e;

  // pick one command from a written byte: release > seize > request
  function automatic cmd_e decode_cmd(logic [7:0] d);
    if (d[B_ACT])        return CMD_REL;
    else if (d[B_SEIZE]) return CMD_SEIZE;
    else if (d[B_REQ])   return CMD_REQ;
    return CMD_NONE;
  endfunction

  // highest set bit of an up-to-8-bit request vector
  function automatic logic [IDX_W-1:0] top_index(logic [LOC_MAX-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < LOC_MAX; i++)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [7:0] pack_access(logic act, logic szd, logic pend,
                                             logic rq, logic est);
    logic [7:0] b;
    b          = 8'h00;
    b[B_VALID] = 1'b1;
    b[B_ACT]   = act;
    b[B_SZD]   = szd;
    b[B_PEND]  = pend;
    b[B_REQ]   = rq;
    b[B_EST]   = ~est;
    return b;
  endfunction
endpackage

// File: rtl/loc_addr_decode.sv
module loc_addr_decode
  import loc_arb_pkg::*;
#(
  parameter int NLOC     = 5,
  parameter int LOC_BITS = 3,
  parameter int OFF_BITS = 12
) (
  input  logic                         bus_req,
  input  logic                         bus_we,
  input  logic [LOC_BITS+OFF_BITS-1:0] bus_addr,
  output logic [LOC_BITS-1:0]          loc_sel,
  output logic                         loc_ok,
  output logic                         off_zero,
  output logic                         wr_evt,
  output logic                         rd_evt
);
  assign loc_sel  = bus_addr[LOC_BITS+OFF_BITS-1:OFF_BITS];
  assign loc_ok   = (32'(loc_sel) < NLOC);
  assign off_zero = (bus_addr[OFF_BITS-1:0] == '0);
  assign wr_evt   = bus_req && bus_we && loc_ok && off_zero;
  assign rd_evt   = bus_req && !bus_we;
endmodule

// File: rtl/loc_owner_ctrl.sv
module loc_owner_ctrl
  import loc_arb_pkg::*;
#(
  parameter int NLOC = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_evt,
  input  logic [IDX_W-1:0] wr_loc,
  input  logic [7:0]       wr_data,
  output logic             own_vld,
  output logic [IDX_W-1:0] own_idx,
  output logic [NLOC-1:0]  req_vec,
  output logic [NLOC-1:0]  szd_vec,
  output logic             grant_evt,
  output logic [IDX_W-1:0] grant_idx
);
  cmd_e             cmd;
  logic             w_vld;
  logic [IDX_W-1:0] w_idx;
  logic [NLOC-1:0]  w_req, w_szd, n_req;
  logic [LOC_MAX-1:0] req_ext;
  logic             writer_owns;

  assign cmd         = wr_evt ? decode_cmd(wr_data) : CMD_NONE;
  assign writer_owns = own_vld && (own_idx == wr_loc);

  // apply the bus command
  always_comb begin
    w_vld = own_vld;
    w_idx = own_idx;
    w_req = req_vec;
    w_szd = szd_vec;
    unique case (cmd)
      CMD_REL: begin
        w_req[wr_loc] = 1'b0;
        w_szd[wr_loc] = 1'b0;
        if (writer_owns) w_vld = 1'b0;
      end
      CMD_SEIZE: begin
        if (!own_vld || (own_idx < wr_loc)) begin
          if (own_vld) w_szd[own_idx] = 1'b1;
          w_vld         = 1'b1;
          w_idx         = wr_loc;
          w_req[wr_loc] = 1'b0;
        end
      end
      CMD_REQ: begin
        if (!writer_owns) w_req[wr_loc] = 1'b1;
      end
      default: ;
    endcase
  end

  // grant the highest waiting requester when free
  always_comb begin
    req_ext             = '0;
    req_ext[NLOC-1:0]   = w_req;
    grant_evt           = !w_vld && (|w_req);
    grant_idx           = top_index(req_ext);
    n_req               = w_req;
    if (grant_evt) n_req[grant_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_idx <= '0;
      req_vec <= '0;
      szd_vec <= '0;
    end else begin
      own_vld <= w_vld || grant_evt;
      own_idx <= grant_evt ? grant_idx : w_idx;
      req_vec <= n_req;
      szd_vec <= w_szd;
    end
  end

  // owner never keeps a pending request of its own
  assert_owner_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    own_vld |-> !req_vec[own_idx]);

  // without a bus write, ownership stays put
  assert_owner_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && own_vld) |=> (own_vld && $stable(own_idx)));

  // a free device with waiting requests does not stay free
  assert_free_grants_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!own_vld && (|req_vec)) |-> 1'b0);

  for (genvar i = 0; i < NLOC; i++) begin : g_szd_chk
    assert_seize_prev_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(szd_vec[i]) |-> ($past(own_vld) && ($past(own_idx) == IDX_W'(i))));
    assert_seized_clear_by_self_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(szd_vec[i]) |-> ($past(wr_evt) && ($past(wr_loc) == IDX_W'(i))));
  end
endmodule

// File: rtl/loc_read_mux.sv
module loc_read_mux
  import loc_arb_pkg::*;
#(
  parameter int NLOC     = 5,
  parameter int LOC_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_evt,
  input  logic [LOC_BITS-1:0] loc_sel,
  input  logic                loc_ok,
  input  logic                off_zero,
  input  logic                own_vld,
  input  logic [IDX_W-1:0]    own_idx,
  input  logic [NLOC-1:0]     req_vec,
  input  logic [NLOC-1:0]     szd_vec,
  input  logic                os_established,
  output logic [7:0]          rdata
);
  logic [IDX_W-1:0] li;
  logic [NLOC-1:0]  self_mask;
  logic             act, pend;
  logic [7:0]       rbyte;

  assign li        = IDX_W'(loc_sel);
  assign self_mask = NLOC'(1) << li;
  assign act       = own_vld && (own_idx == li);
  assign pend      = |(req_vec & ~self_mask);

  always_comb begin
    if (!loc_ok)        rbyte = 8'hFF;
    else if (!off_zero) rbyte = 8'h00;
    else rbyte = pack_access(act, |(szd_vec & self_mask), pend,
                             |(req_vec & self_mask), os_established);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= 8'h00;
    else if (rd_evt) rdata <= rbyte;
  end

  assert_absent_reads_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && !loc_ok) |=> (rdata == 8'hFF));

  assert_valid_bit_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && loc_ok && off_zero) |=> rdata[B_VALID]);
endmodule

// File: rtl/loc_access_arb.sv
module loc_access_arb
  import loc_arb_pkg::*;
#(
  parameter int NLOC     = 5,
  parameter int LOC_BITS = 3,
  parameter int OFF_BITS = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_req,
  input  logic                         bus_we,
  input  logic [LOC_BITS+OFF_BITS-1:0] bus_addr,
  input  logic [7:0]                   bus_wdata,
  input  logic                         os_established,
  output logic                         bus_ack,
  output logic [7:0]                   bus_rdata
);
  logic [LOC_BITS-1:0] loc_sel;
  logic                loc_ok, off_zero, wr_evt, rd_evt;
  logic                own_vld, grant_evt;
  logic [IDX_W-1:0]    own_idx, grant_idx;
  logic [NLOC-1:0]     req_vec, szd_vec;

  initial begin
    assert (NLOC >= 1 && NLOC <= LOC_MAX && (1 << LOC_BITS) >= NLOC)
      else $error("locality count does not fit");
  end

  loc_addr_decode #(.NLOC(NLOC), .LOC_BITS(LOC_BITS), .OFF_BITS(OFF_BITS)) u_dec (
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .loc_sel(loc_sel), .loc_ok(loc_ok), .off_zero(off_zero),
    .wr_evt(wr_evt), .rd_evt(rd_evt));

  loc_owner_ctrl #(.NLOC(NLOC)) u_own (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_loc(IDX_W'(loc_sel)),
    .wr_data(bus_wdata), .own_vld(own_vld), .own_idx(own_idx),
    .req_vec(req_vec), .szd_vec(szd_vec),
    .grant_evt(grant_evt), .grant_idx(grant_idx));

  loc_read_mux #(.NLOC(NLOC), .LOC_BITS(LOC_BITS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .loc_sel(loc_sel),
    .loc_ok(loc_ok), .off_zero(off_zero), .own_vld(own_vld), .own_idx(own_idx),
    .req_vec(req_vec), .szd_vec(szd_vec), .os_established(os_established),
    .rdata(bus_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_ack <= 1'b0;
    else        bus_ack <= bus_req;
  end

  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);
  assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ack);
  assert_grant_only_when_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_evt |=> own_vld);
endmodule

// File: tb/loc_access_arb_tb.sv
module loc_access_arb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 5;

  logic        clk = 0, rst_n = 0;
  logic        bus_req = 0, bus_we = 0;
  logic [14:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        os_established = 0;
  logic        bus_ack;
  logic [7:0]  bus_rdata;

  int errors = 0, checks = 0;
  int m_owner = -1;
  bit m_req[NL];
  bit m_szd[NL];
  bit req_q = 0;
  bit running = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loc_access_arb u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .os_established(os_established),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle acknowledge comparison
  always @(posedge clk) req_q <= rst_n ? bus_req : 1'b0;
  always @(negedge clk) if (running) check("R2 ack", bus_ack, req_q);

  function automatic int model_read(int loc, int off);
    int b, pend;
    if (loc >= NL) return 8'hFF;
    if (off != 0)  return 8'h00;
    pend = 0;
    foreach (m_req[i]) if (i != loc && m_req[i]) pend = 1;
    b = 128 + (os_established ? 0 : 1);
    if (m_owner == loc) b += 32;
    if (m_szd[loc])     b += 16;
    if (pend)           b += 4;
    if (m_req[loc])     b += 2;
    return b;
  endfunction

  function automatic void model_write(int loc, int off, int d);
    if (loc >= NL || off != 0) return;
    if (d & 32) begin
      m_req[loc] = 0; m_szd[loc] = 0;
      if (m_owner == loc) m_owner = -1;
    end else if (d & 8) begin
      if (m_owner < loc) begin
        if (m_owner >= 0) m_szd[m_owner] = 1;
        m_owner = loc; m_req[loc] = 0;
      end
    end else if (d & 2) begin
      if (m_owner != loc) m_req[loc] = 1;
    end
    if (m_owner < 0)
      for (int i = NL-1; i >= 0; i--)
        if (m_req[i]) begin m_owner = i; m_req[i] = 0; break; end
  endfunction

  task automatic wr(int loc, int off, int d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = 15'((loc << 12) | off); bus_wdata = 8'(d);
    @(posedge clk); #1;
    model_write(loc, off, d);
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(string tag, int loc, int off);
    int exp;
    @(negedge clk);
    exp = model_read(loc, off);
    bus_req = 1; bus_we = 0; bus_addr = 15'((loc << 12) | off);
    @(negedge clk);
    bus_req = 0;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; running = 1;
    // R1 reset state
    for (int l = 0; l < NL; l++) rd("R1 reset", l, 0);
    check("R1 value", model_read(0, 0), 8'h81);
    // R9 establishment bit
    os_established = 1; rd("R9 est", 0, 0); os_established = 0; rd("R9 est", 0, 0);
    // R3 idle grant
    wr(2, 0, 8'h02); rd("R3 grant", 2, 0);
    check("R3 value", model_read(2, 0), 8'hA1);
    // R4 waiting requests, owner request ignored
    wr(0, 0, 8'h02); wr(1, 0, 8'h02); wr(2, 0, 8'h02);
    rd("R4 req", 0, 0); rd("R4 owner pend", 2, 0); rd("R4 req", 1, 0);
    check("R4 value", model_read(2, 0), 8'hA5);
    // R5/R6 release hands to highest waiter
    wr(2, 0, 8'h20); rd("R6 highest", 1, 0); rd("R5 released", 2, 0);
    check("R6 owner", m_owner, 1);
    wr(1, 0, 8'h20); rd("R5 handoff", 0, 0);
    // R7 seize
    wr(3, 0, 8'h08); rd("R7 seized", 0, 0); rd("R7 seizer", 3, 0);
    check("R7 value", model_read(0, 0), 8'h91);
    wr(1, 0, 8'h08); rd("R7 lower seize", 3, 0); rd("R7 lower seize", 1, 0);
    // R8 clear seized
    wr(0, 0, 8'h20); rd("R8 cleared", 0, 0);
    // R10 absent windows
    for (int l = 5; l < 8; l++) begin rd("R10 absent", l, 0); rd("R10 absent", l, 3); end
    wr(7, 0, 8'h08); rd("R10 write ignored", 3, 0);
    // R11 other offsets
    rd("R11 offset", 1, 4); rd("R11 offset", 3, 12'hFFF);
    wr(4, 12'h018, 8'h08); rd("R11 write ignored", 3, 0); rd("R11 write ignored", 4, 0);
    // R12 command priority
    wr(4, 0, 8'h2A); rd("R12 release wins", 4, 0); rd("R12 release wins", 3, 0);
    wr(4, 0, 8'h0A); rd("R12 seize wins", 4, 0); rd("R12 seize wins", 3, 0);
    wr(4, 0, 8'h02); rd("R12 owner req ignored", 4, 0);
    // random mix against the model
    for (int n = 0; n < 600; n++) begin
      int loc, off, d;
      loc = $urandom_range(0, 7);
      off = ($urandom_range(0, 7) == 0) ? $urandom_range(1, 4095) : 0;
      d   = $urandom_range(0, 255);
      if ($urandom_range(0, 1)) wr(loc, off, d);
      else rd("R2 random", loc, off);
    end
    for (int l = 0; l < 8; l++) rd("R2 final", l, 0);
    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule